// File: doc/BRIEF.md
# Significance-Mode Floating-Point Unit

This block adds, subtracts and multiplies 68-bit floating-point words in a mode that keeps the significance of the operands instead of renormalizing the result. Each word is a sign and a 56-bit coefficient magnitude with four integer bits, a base-16 exponent, and a 3-bit tag. The tag plays no part in the arithmetic. It is split off on entry and attached again to the result.

Add and subtract align the operand with the smaller exponent to the other, one hex digit at a time. The result is never shifted left, so any leading zero digits that a cancellation leaves behind stay in the coefficient. Multiply first normalizes only the operand whose coefficient is larger in magnitude. It then runs a one-bit-per-cycle shift-add loop and truncates the product without normalizing it afterwards. In every path, a result of sixteen or more is shifted right by one digit. The block raises an overflow flag when the exponent runs past its top.

The host pulses a start strobe with the operands and an opcode. The unit answers with a one-cycle done strobe, and the result stays on the outputs until the next done.

Top module: `sigfp_unit`

## Requirements
- R1: Word layout is tag in bits 67:65, sign in bit 64, coefficient magnitude in bits 63:8 (binary point between bits 60 and 59, i.e. value = coef/2^52), exponent in bits 7:0 with bias 128 and base 16. Opcode 2'b00 adds, 2'b01 subtracts (operand B's sign inverted), 2'b10 and 2'b11 multiply.
- R2: The result tag equals operand A's tag and never influences the arithmetic.
- R3: Add/subtract shifts the smaller-exponent coefficient right by four bits per unit of exponent difference, dropping bits shifted out. The result takes the larger exponent. Opposite signs subtract the smaller aligned magnitude from the larger, and the result takes the sign of the larger. No left shift is ever applied.
- R4: When a raw sum or product magnitude reaches 16.0 or more, it is shifted right by one hex digit and the exponent is incremented.
- R5: If the final exponent exceeds 255, the overflow output is 1 and the exponent field is 8'hFF. Otherwise the overflow output is 0.
- R6: Multiply normalizes only the operand with the larger coefficient magnitude (A on a tie). It shifts left by whole hex digits until the top digit is non-zero or its exponent reaches 0. The product is truncated to 52 fraction bits with exponent eA+eB-128, and no post-normalization is applied.
- R7: A final exponent below 0 yields a zero coefficient, sign 0 and exponent 0 (tag kept). Any zero coefficient result has sign 0.
- R8: If start is sampled high in cycle n, done is high in cycle n+3 for add/subtract and in cycle n+3+56 for multiply.
- R9: Done lasts one cycle. Result and overflow hold until the next done. A start while an operation is in flight is ignored. A start in the done cycle is accepted.
- R10: After reset, done, overflow and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation with the present operands |
| op_i | input | 2 | Operation select (R1) |
| a_i | input | 68 | Operand A word |
| b_i | input | 68 | Operand B word |
| result_o | output | 68 | Result word |
| ovf_o | output | 1 | Exponent overflow of the last result |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Acceptance of a new start and delivery of the previous result can fall in the same cycle. Done rises while the unit has already returned to idle, so a start in that cycle must be taken. The bench launches every operation in the exact cycle where it observes done, runs operations back to back, and checks both results and the exact latency of each. The opposite collision, a start during a multiply, is injected mid-loop. The bench then checks that the multiply result is unchanged and that no extra done follows.

// File: rtl/sigfp_pkg.sv
package sigfp_pkg;
  localparam int TAG_W  = 3;
  localparam int EXP_W  = 8;
  localparam int COEF_W = 56;
  localparam int DIG_W  = 4;
  localparam int WORD_W = TAG_W + 1 + COEF_W + EXP_W;
  localparam int WIDE_W = COEF_W + DIG_W;
  localparam int EXS_W  = EXP_W + 2;
  localparam int BIAS   = 2 ** (EXP_W - 1);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              sign;
    logic [COEF_W-1:0] coef;
    logic [EXP_W-1:0]  expo;
  } fp_word_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PREP,
    S_MUL,
    S_FIN
  } fsm_t;
endpackage

// File: rtl/sigfp_align_add.sv
module sigfp_align_add #(
  parameter int COEF_W = 56,
  parameter int EXP_W  = 8,
  parameter int DIG_W  = 4,
  localparam int WIDE_W = COEF_W + DIG_W,
  localparam int EXS_W  = EXP_W + 2
) (
  input  logic              sa_i,
  input  logic [COEF_W-1:0] ma_i,
  input  logic [EXP_W-1:0]  ea_i,
  input  logic              sb_i,
  input  logic [COEF_W-1:0] mb_i,
  input  logic [EXP_W-1:0]  eb_i,
  output logic              sr_o,
  output logic [WIDE_W-1:0] mr_o,
  output logic [EXS_W-1:0]  er_o
);
  logic              a_lead;
  logic [EXP_W-1:0]  diff;
  logic [COEF_W-1:0] mx, my;
  logic              sx, sy;

  always_comb begin
    a_lead = (ea_i >= eb_i);
    diff   = a_lead ? (ea_i - eb_i) : (eb_i - ea_i);
    mx     = a_lead ? ma_i : mb_i;
    sx     = a_lead ? sa_i : sb_i;
    sy     = a_lead ? sb_i : sa_i;
    my     = (a_lead ? mb_i : ma_i) >> (32'(diff) * DIG_W);
    er_o   = EXS_W'(a_lead ? ea_i : eb_i);
    if (sx == sy) begin
      mr_o = WIDE_W'(mx) + WIDE_W'(my);
      sr_o = sx;
    end else if (mx >= my) begin
      mr_o = WIDE_W'(mx - my);
      sr_o = sx;
    end else begin
      mr_o = WIDE_W'(my - mx);
      sr_o = sy;
    end
  end

  // R3: a like-signed sum never falls below the leading operand
  always_comb begin
    if (sx == sy) begin
      a_r3_sum_no_wrap: assert (mr_o >= WIDE_W'(mx));
    end
  end
endmodule

// File: rtl/sigfp_prenorm.sv
module sigfp_prenorm #(
  parameter int COEF_W = 56,
  parameter int EXP_W  = 8,
  parameter int DIG_W  = 4,
  localparam int NDIG = COEF_W / DIG_W,
  localparam int LZ_W = $clog2(NDIG + 1)
) (
  input  logic [COEF_W-1:0] ma_i,
  input  logic [EXP_W-1:0]  ea_i,
  input  logic [COEF_W-1:0] mb_i,
  input  logic [EXP_W-1:0]  eb_i,
  output logic [COEF_W-1:0] ma_o,
  output logic [EXP_W-1:0]  ea_o,
  output logic [COEF_W-1:0] mb_o,
  output logic [EXP_W-1:0]  eb_o
);
  logic              pick_a;
  logic [COEF_W-1:0] src, nsrc;
  logic [EXP_W-1:0]  se, nse, sh;
  logic [LZ_W-1:0]   lz;
  logic              seen;

  always_comb begin
    pick_a = (ma_i >= mb_i);
    src    = pick_a ? ma_i : mb_i;
    se     = pick_a ? ea_i : eb_i;
    lz     = '0;
    seen   = 1'b0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (src[i*DIG_W +: DIG_W] != '0) seen = 1'b1;
      else if (!seen) lz = lz + 1'b1;
    end
    if (src == '0)              sh = '0;
    else if (EXP_W'(lz) > se)   sh = se;
    else                        sh = EXP_W'(lz);
    nsrc = src << (32'(sh) * DIG_W);
    nse  = se - sh;
    ma_o = pick_a ? nsrc : ma_i;
    ea_o = pick_a ? nse  : ea_i;
    mb_o = pick_a ? mb_i : nsrc;
    eb_o = pick_a ? eb_i : nse;
  end

  // R6: unless the exponent floor stopped it, the shifted operand leads with a non-zero digit
  always_comb begin
    if (nsrc != '0 && nse != '0) begin
      a_r6_norm_lead: assert (nsrc[COEF_W-1 -: DIG_W] != '0);
    end
  end
endmodule

// File: rtl/sigfp_mul_seq.sv
module sigfp_mul_seq #(
  parameter int COEF_W = 56,
  localparam int CNT_W = $clog2(COEF_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [COEF_W-1:0]   mcand_i,
  input  logic [COEF_W-1:0]   mplier_i,
  output logic                last_o,
  output logic [2*COEF_W-1:0] prod_o
);
  logic [COEF_W-1:0] hi_q, hi_d, lo_q, lo_d, mc_q, mc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [COEF_W:0]   psum;

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    mc_d  = mc_q;
    cnt_d = cnt_q;
    psum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    if (load_i) begin
      hi_d  = '0;
      lo_d  = mplier_i;
      mc_d  = mcand_i;
      cnt_d = '0;
    end else if (step_i) begin
      hi_d  = psum[COEF_W:1];
      lo_d  = {psum[0], lo_q[COEF_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      mc_q  <= '0;
      cnt_q <= '0;
    end else if (load_i || step_i) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      mc_q  <= mc_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == CNT_W'(COEF_W - 1));
  assign prod_o = {hi_q, lo_q};

  // R8: the controller never steps past the multiplier width
  a_r8_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q < CNT_W'(COEF_W)));
endmodule

// File: rtl/sigfp_pack.sv
module sigfp_pack #(
  parameter int COEF_W = 56,
  parameter int EXP_W  = 8,
  parameter int DIG_W  = 4,
  parameter int TAG_W  = 3,
  localparam int WIDE_W = COEF_W + DIG_W,
  localparam int EXS_W  = EXP_W + 2,
  localparam int WORD_W = TAG_W + 1 + COEF_W + EXP_W
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              sign_i,
  input  logic [WIDE_W-1:0] mag_i,
  input  logic [EXS_W-1:0]  exp_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o
);
  logic [WIDE_W-1:0] m;
  logic [EXS_W-1:0]  e;
  logic [COEF_W-1:0] coef;
  logic [EXP_W-1:0]  ef;
  logic              s;

  always_comb begin
    m = mag_i;
    e = exp_i;
    if (mag_i[WIDE_W-1 -: DIG_W] != '0) begin
      m = mag_i >> DIG_W;
      e = exp_i + EXS_W'(1);
    end
    coef  = m[COEF_W-1:0];
    ef    = e[EXP_W-1:0];
    s     = sign_i;
    ovf_o = 1'b0;
    if (e[EXS_W-1]) begin
      coef = '0;
      ef   = '0;
    end else if (e[EXS_W-2:EXP_W] != '0) begin
      ovf_o = 1'b1;
      ef    = '1;
    end
    if (coef == '0) s = 1'b0;
    word_o = {tag_i, s, coef, ef};
  end
endmodule

// File: rtl/sigfp_unit.sv
module sigfp_unit
  import sigfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              done_o
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  fsm_t            state_q, state_d;
  logic [1:0]      op_q;
  fp_word_t        a_q, b_q;
  logic            ssum_q;
  logic [WIDE_W-1:0] msum_q;
  logic [EXS_W-1:0]  esum_q, emul_q, emul_d;
  logic [WORD_W-1:0] res_q;
  logic            ovf_q, done_q, done_d;

  logic            load_en, add_en, mload, mstep, fin_en, mlast;

  // add / subtract path
  logic              ssum_d;
  logic [WIDE_W-1:0] msum_d;
  logic [EXS_W-1:0]  esum_d;

  sigfp_align_add #(.COEF_W(COEF_W), .EXP_W(EXP_W), .DIG_W(DIG_W)) u_add (
    .sa_i (a_q.sign),
    .ma_i (a_q.coef),
    .ea_i (a_q.expo),
    .sb_i (b_q.sign ^ op_q[0]),
    .mb_i (b_q.coef),
    .eb_i (b_q.expo),
    .sr_o (ssum_d),
    .mr_o (msum_d),
    .er_o (esum_d)
  );

  // multiply path
  logic [COEF_W-1:0]   na, nb;
  logic [EXP_W-1:0]    nea, neb;
  logic [2*COEF_W-1:0] prod;

  sigfp_prenorm #(.COEF_W(COEF_W), .EXP_W(EXP_W), .DIG_W(DIG_W)) u_norm (
    .ma_i (a_q.coef),
    .ea_i (a_q.expo),
    .mb_i (b_q.coef),
    .eb_i (b_q.expo),
    .ma_o (na),
    .ea_o (nea),
    .mb_o (nb),
    .eb_o (neb)
  );

  sigfp_mul_seq #(.COEF_W(COEF_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load_i   (mload),
    .step_i   (mstep),
    .mcand_i  (na),
    .mplier_i (nb),
    .last_o   (mlast),
    .prod_o   (prod)
  );

  // repack
  logic              pk_sign;
  logic [WIDE_W-1:0] pk_mag;
  logic [EXS_W-1:0]  pk_exp;
  logic [WORD_W-1:0] pk_word;
  logic              pk_ovf;

  always_comb begin
    if (op_q[1]) begin
      pk_sign = a_q.sign ^ b_q.sign;
      pk_mag  = prod[2*COEF_W-1 -: WIDE_W];
      pk_exp  = emul_q;
    end else begin
      pk_sign = ssum_q;
      pk_mag  = msum_q;
      pk_exp  = esum_q;
    end
  end

  sigfp_pack #(.COEF_W(COEF_W), .EXP_W(EXP_W), .DIG_W(DIG_W), .TAG_W(TAG_W)) u_pack (
    .tag_i  (a_q.tag),
    .sign_i (pk_sign),
    .mag_i  (pk_mag),
    .exp_i  (pk_exp),
    .word_o (pk_word),
    .ovf_o  (pk_ovf)
  );

  // control
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    add_en  = 1'b0;
    mload   = 1'b0;
    mstep   = 1'b0;
    fin_en  = 1'b0;
    done_d  = 1'b0;
    emul_d  = EXS_W'(nea) + EXS_W'(neb) - EXS_W'(BIAS);
    unique case (state_q)
      S_IDLE: if (start_i) begin
        load_en = 1'b1;
        state_d = S_PREP;
      end
      S_PREP: begin
        if (op_q[1]) begin
          mload   = 1'b1;
          state_d = S_MUL;
        end else begin
          add_en  = 1'b1;
          state_d = S_FIN;
        end
      end
      S_MUL: begin
        mstep = 1'b1;
        if (mlast) state_d = S_FIN;
      end
      S_FIN: begin
        fin_en  = 1'b1;
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (load_en) begin
      op_q <= op_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ssum_q <= 1'b0;
      msum_q <= '0;
      esum_q <= '0;
    end else if (add_en) begin
      ssum_q <= ssum_d;
      msum_q <= msum_d;
      esum_q <= esum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) emul_q <= '0;
    else if (mload) emul_q <= emul_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (fin_en) begin
      res_q <= pk_word;
      ovf_q <= pk_ovf;
    end
  end

  assign result_o = res_q;
  assign ovf_o    = ovf_q;
  assign done_o   = done_q;

  // R9: completion strobe is a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |=> !done_o);

  // R9: a start while busy leaves the captured operation untouched
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q != S_IDLE && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));

  // R9: the result only changes together with the done strobe
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !done_d |=> $stable(result_o));
endmodule

// File: tb/tb_sigfp_unit.sv
module tb_sigfp_unit;
  import sigfp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_ADD = 3;
  localparam int LAT_MUL = 3 + COEF_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [1:0]        op_i;
  logic [WORD_W-1:0] a_i, b_i;
  logic [WORD_W-1:0] result_o;
  logic              ovf_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] prev_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  sigfp_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .ovf_o(ovf_o), .done_o(done_o)
  );

  function automatic logic [WORD_W-1:0] mkw(logic [2:0] t, logic s, logic [55:0] c, logic [7:0] e);
    return {t, s, c, e};
  endfunction

  // behavioural model of the requirements: returns {ovf, word}
  function automatic logic [WORD_W:0] model(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b, logic [1:0] op);
    logic [2:0]   ta;
    logic         sa, sb, sbe, sx, sy, s;
    logic [63:0]  ma, mb, mx, my, m;
    logic [127:0] prod;
    int ea, eb, ex, d;
    logic ov;
    ta = a[67:65]; sa = a[64]; ma = {8'b0, a[63:8]}; ea = int'(a[7:0]);
    sb = b[64];    mb = {8'b0, b[63:8]}; eb = int'(b[7:0]);
    if (!op[1]) begin
      sbe = sb ^ op[0];
      if (ea >= eb) begin
        d = ea - eb; ex = ea; mx = ma; sx = sa; sy = sbe;
        my = (d >= 14) ? 64'd0 : (mb >> (4 * d));
      end else begin
        d = eb - ea; ex = eb; mx = mb; sx = sbe; sy = sa;
        my = (d >= 14) ? 64'd0 : (ma >> (4 * d));
      end
      if (sx == sy)      begin m = mx + my; s = sx; end
      else if (mx >= my) begin m = mx - my; s = sx; end
      else               begin m = my - mx; s = sy; end
    end else begin
      if (ma >= mb) begin
        for (int k = 0; k < 14; k++)
          if (ma != 0 && ma[55:52] == 0 && ea > 0) begin ma = ma << 4; ea--; end
      end else begin
        for (int k = 0; k < 14; k++)
          if (mb != 0 && mb[55:52] == 0 && eb > 0) begin mb = mb << 4; eb--; end
      end
      prod = {64'd0, ma} * {64'd0, mb};
      m  = prod[115:52];
      ex = ea + eb - 128;
      s  = sa ^ sb;
    end
    if (m >= (64'd1 << 56)) begin m = m >> 4; ex++; end
    ov = 1'b0;
    if (ex > 255) begin ov = 1'b1; ex = 255; end
    else if (ex < 0) begin m = 0; s = 1'b0; ex = 0; end
    if (m == 0) s = 1'b0;
    return {ov, ta, s, m[55:0], 8'(ex)};
  endfunction

  task automatic check(string req, logic [WORD_W:0] act, logic [WORD_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; drives start in that cycle, returns at the negedge where done is seen
  task automatic run(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b, logic [1:0] op,
                     bit inject, string req);
    logic [WORD_W:0] expv;
    int lat, j;
    bit got;
    expv = model(a, b, op);
    lat  = op[1] ? LAT_MUL : LAT_ADD;
    a_i = a; b_i = b; op_i = op; start_i = 1'b1;
    got = 1'b0; j = 0;
    while (!got && j < lat + 10) begin
      @(negedge clk); j++;
      if (j == 1) begin
        start_i = 1'b0;
        check("R9 pulse", {1'b0, done_o}, '0);
        check("R9 hold", {1'b0, result_o}, {1'b0, prev_res});
      end
      if (inject && j == 5) begin
        start_i = 1'b1; a_i = ~a; b_i = a; op_i = 2'b00;
      end
      if (inject && j == 6) start_i = 1'b0;
      if (done_o) got = 1'b1;
    end
    check("R8 latency", (WORD_W+1)'(got ? j : -1), (WORD_W+1)'(lat));
    check(req, {ovf_o, result_o}, expv);
    prev_res = result_o;
  endtask

  function automatic logic [55:0] rcoef();
    logic [55:0] c;
    c = {$urandom, $urandom} & {56{1'b1}};
    return c >> (4 * ($urandom % 15));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [55:0] ONE   = 56'h10000000000000;
  localparam logic [55:0] EIGHT = 56'h80000000000000;

  initial begin
    logic [WORD_W-1:0] a, b;
    void'($urandom(32'h5EED_0F17));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    prev_res = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 reset", {ovf_o, result_o}, '0);
    check("R10 done", {1'b0, done_o}, '0);

    // R3 plain add
    run(mkw(0,0,ONE,128), mkw(0,0,ONE,128), 2'b00, 0, "R3 add");
    check("R3 add value", {1'b0, result_o}, {1'b0, mkw(0,0,56'h20000000000000,128)});
    // R4 carry into guard digit
    run(mkw(0,0,EIGHT,128), mkw(0,0,EIGHT,128), 2'b00, 0, "R4 add shift");
    check("R4 add value", {1'b0, result_o}, {1'b0, mkw(0,0,ONE,129)});
    // R3 alignment by two digits
    run(mkw(0,0,ONE,130), mkw(0,1,56'h23456789ABCDEF,128), 2'b00, 0, "R3 align");
    // R7 exact cancellation
    run(mkw(0,1,ONE,128), mkw(0,1,ONE,128), 2'b01, 0, "R7 cancel");
    check("R7 zero value", {1'b0, result_o}, {1'b0, mkw(0,0,0,128)});
    // R3 no left shift after cancellation
    run(mkw(0,0,ONE,128), mkw(0,0,56'h0F000000000000,128), 2'b01, 0, "R3 no renorm");
    check("R3 no renorm value", {1'b0, result_o}, {1'b0, mkw(0,0,56'h01000000000000,128)});
    // R5 exponent overflow on add
    run(mkw(0,0,EIGHT,255), mkw(0,0,EIGHT,255), 2'b00, 0, "R5 add ovf");
    check("R5 flag", {1'b0, result_o[7:0], ovf_o}, {1'b0, 8'hFF, 1'b1});
    // R6 only the larger operand is normalized
    run(mkw(0,0,56'h01000000000000,128), mkw(0,0,56'h00100000000000,128), 2'b10, 0, "R6 mul");
    check("R6 mul value", {1'b0, result_o}, {1'b0, mkw(0,0,56'h00100000000000,127)});
    // R6 tie picks A, opcode 11 multiplies
    run(mkw(0,1,56'h00300000000000,130), mkw(0,0,56'h00300000000000,129), 2'b11, 0, "R6 tie");
    // R7 exponent underflow on multiply
    run(mkw(0,0,ONE,10), mkw(0,1,ONE,10), 2'b10, 0, "R7 underflow");
    check("R7 underflow value", {1'b0, result_o}, '0);
    // R4 large product
    run(mkw(0,0,56'hFFFFFFFFFFFFFF,128), mkw(0,0,56'hF0000000000000,128), 2'b10, 0, "R4 mul shift");
    // R5 multiply overflow
    run(mkw(0,0,EIGHT,250), mkw(0,0,EIGHT,200), 2'b10, 0, "R5 mul ovf");
    // R2 tag from A only
    run(mkw(3'b101,0,ONE,128), mkw(3'b010,0,ONE,127), 2'b00, 0, "R2 tag");
    check("R2 tag value", {66'd0, result_o[67:65]}, {66'd0, 3'b101});
    // R9 start during multiply is ignored
    run(mkw(3'b001,0,56'h12345678000000,129), mkw(0,1,56'h0ABCDEF0000000,127), 2'b10, 1, "R9 busy");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 no extra done", {1'b0, done_o}, '0);
    end
    prev_res = result_o;

    // R1 random traffic, back to back, with occasional gaps
    for (int n = 0; n < 120; n++) begin
      a = mkw(3'($urandom), 1'($urandom), rcoef(), 8'(120 + $urandom % 17));
      b = mkw(3'($urandom), 1'($urandom), rcoef(), 8'(120 + $urandom % 17));
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        check("R9 idle", {1'b0, done_o}, '0);
      end
      run(a, b, 2'($urandom), 0, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule